// File: doc/BRIEF.md
# Timer Interrupt Flag and Mask Controller

This block gathers event flags for the timer, gates each one with its enable bit, and drives one interrupt request line. Outside compare logic and capture logic send one-cycle pulses. The block latches each pulse as a sticky flag. Software reads the flags and clears them over a small synchronous register bus. A second group of four flags (overflow, real-time tick, accumulator overflow and accumulator edge) comes in as levels from other logic. The block does not hold those flags, but it does hold their enables.

Three byte registers sit at consecutive bus offsets:

| Offset | Contents |
|--------|----------|
| 0x22 | Enables for the flag register |
| 0x23 | Flag register |
| 0x24 | Enables for the second flag group, plus a two-bit prescaler select |

In normal operation the prescaler select is locked after one write, or after a fixed number of cycles following reset, whichever comes first. A mode input lifts that lock for test and bring-up.

Top module: `tmr_irq_top`

## Requirements
- R1: An `evtPulse[i]` high at a rising edge sets flag bit i, which reads as 1 at offset 0x23 from the next cycle on. Bits 7..3 belong to compare channels 1..5 and bits 2..0 belong to capture channels 1..3.
- R2: A bus write to offset 0x23 clears every flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R3: If a flag's event pulse and a clearing write hit that flag at the same edge, the flag ends up set.
- R4: Offset 0x22 holds an 8-bit enable register that can be written and read back. Bit i enables flag bit i.
- R5: At offset 0x24, bits 7..4 are enables that can always be written. Bits 3..2 always read 0. Bits 1..0 read back the prescaler select, which also drives `prescSel`.
- R6: `irq` is a level signal. It is 1 exactly when some flag bit and its enable at 0x22 are both 1, or when some `flag2In[j]` and bit j+4 of offset 0x24 are both 1. It follows `flag2In` in the same cycle.
- R7: With `specialMode` low, the first write to 0x24 updates the prescaler select if it lands at one of the edges 0..WINDOW-1 after reset release. Edge 0 is the first rising edge with `rstN` high. Every later write to 0x24 leaves the prescaler select unchanged.
- R8: With `specialMode` low, a write to 0x24 at edge WINDOW or later leaves the prescaler select unchanged, even if no earlier write was made.
- R9: With `specialMode` high, every write to 0x24 updates the prescaler select, at any time.
- R10: While `rstN` is low, all registers read 0, `prescSel` is 0 and `irq` is 0.
- R11: Reads from any other address return 0, and writes to any other address change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| specialMode | input | 1 | Removes the lock on prescaler writes |
| evtPulse | input | 8 | Event pulses from compare and capture logic |
| flag2In | input | 4 | Overflow, real-time, accumulator overflow and accumulator edge flags (bits 3..0) |
| busAddr | input | 8 | Register address |
| busWe | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from `busAddr` |
| irq | output | 1 | Interrupt request level |
| prescSel | output | 2 | Prescaler select |

## Verification
The bench targets these corner cases:

- **Set and clear at the same edge.** A design that let the clear win would drop an event and leave `irq` low.
- **Clear writes with zero bits.** A design that treated a 0 bit as a clear would wipe out pending flags.
- **Prescaler lock.** The bench writes once at the start of the window, writes again inside the window, and writes late after a fresh reset with no earlier write. A design that counted the window wrongly, or never locked, would show a changed `prescSel`.
- **Special mode.** Repeated writes in special mode must each take effect.
- **Enable pairing for the second flag group.** The bench exercises each `flag2In` line against its enable bit, so an enable bit paired with the wrong flag line would be caught.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;

  typedef struct packed {
    logic wrMask1;
    logic clrFlags;
    logic wrMask2En;
    logic wrPresc;
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_MASK1 = 2'd1,
    RD_FLAG  = 2'd2,
    RD_MASK2 = 2'd3
  } rdSel_t;

endpackage

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import tmr_irq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int MASK1_ADDR = 'h22,
  parameter int FLAG_ADDR  = 'h23,
  parameter int MASK2_ADDR = 'h24,
  parameter int WINDOW     = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              specialMode,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output ctrlStrobe_t       strb,
  output rdSel_t            rdSel
);

  localparam int CNT_W = $clog2(WINDOW + 1);
  localparam logic [CNT_W-1:0] WIN_END = CNT_W'(WINDOW);

  logic [CNT_W-1:0] winCnt;
  logic             onceDone;
  logic             hitMask1, hitFlag, hitMask2;
  logic             windowOpen;

  assign hitMask1   = (busAddr == ADDR_W'(MASK1_ADDR));
  assign hitFlag    = (busAddr == ADDR_W'(FLAG_ADDR));
  assign hitMask2   = (busAddr == ADDR_W'(MASK2_ADDR));
  assign windowOpen = (winCnt < WIN_END);

  always_comb begin
    strb           = '0;
    strb.wrMask1   = busWe && hitMask1;
    strb.clrFlags  = busWe && hitFlag;
    strb.wrMask2En = busWe && hitMask2;
    strb.wrPresc   = busWe && hitMask2 && (specialMode || (windowOpen && !onceDone));
  end

  always_comb begin
    if (hitMask1)      rdSel = RD_MASK1;
    else if (hitFlag)  rdSel = RD_FLAG;
    else if (hitMask2) rdSel = RD_MASK2;
    else               rdSel = RD_NONE;
  end

  // cycles since reset release, saturating at the window length
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           winCnt <= '0;
    else if (windowOpen) winCnt <= winCnt + 1'b1;
  end

  // a normal-mode write uses up the single allowed update
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             onceDone <= 1'b0;
    else if (strb.wrPresc && !specialMode) onceDone <= 1'b1;
  end

endmodule

// File: rtl/tmr_irq_dp.sv
module tmr_irq_dp
  import tmr_irq_pkg::*;
#(
  parameter int OC_NUM  = 5,
  parameter int IC_NUM  = 3,
  parameter int FLAG2_W = 4,
  parameter int PRESC_W = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobe_t               strb,
  input  rdSel_t                    rdSel,
  input  logic [OC_NUM+IC_NUM-1:0]  evtPulse,
  input  logic [OC_NUM+IC_NUM-1:0]  busWdata,
  output logic [OC_NUM+IC_NUM-1:0]  busRdata,
  output logic [OC_NUM+IC_NUM-1:0]  flagQ,
  output logic [OC_NUM+IC_NUM-1:0]  mask1Q,
  output logic [FLAG2_W-1:0]        mask2EnQ,
  output logic [PRESC_W-1:0]        prescQ
);

  localparam int DATA_W = OC_NUM + IC_NUM;
  localparam int PAD_W  = DATA_W - FLAG2_W - PRESC_W;

  logic [PAD_W-1:0] unusedPadBits;
  assign unusedPadBits = busWdata[PRESC_W +: PAD_W];

  // one sticky cell per flag; a set at the same edge beats a clear
  for (genvar i = 0; i < DATA_W; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                              flagQ[i] <= 1'b0;
      else if (evtPulse[i])                   flagQ[i] <= 1'b1;
      else if (strb.clrFlags && busWdata[i])  flagQ[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             mask1Q <= '0;
    else if (strb.wrMask1) mask1Q <= busWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               mask2EnQ <= '0;
    else if (strb.wrMask2En) mask2EnQ <= busWdata[DATA_W-1 -: FLAG2_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             prescQ <= '0;
    else if (strb.wrPresc) prescQ <= busWdata[PRESC_W-1:0];
  end

  always_comb begin
    unique case (rdSel)
      RD_MASK1: busRdata = mask1Q;
      RD_FLAG:  busRdata = flagQ;
      RD_MASK2: busRdata = {mask2EnQ, {PAD_W{1'b0}}, prescQ};
      default:  busRdata = '0;
    endcase
  end

endmodule

// File: rtl/tmr_irq_top.sv
module tmr_irq_top
  import tmr_irq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int OC_NUM     = 5,
  parameter int IC_NUM     = 3,
  parameter int FLAG2_W    = 4,
  parameter int PRESC_W    = 2,
  parameter int MASK1_ADDR = 'h22,
  parameter int FLAG_ADDR  = 'h23,
  parameter int MASK2_ADDR = 'h24,
  parameter int WINDOW     = 64
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     specialMode,
  input  logic [OC_NUM+IC_NUM-1:0] evtPulse,
  input  logic [FLAG2_W-1:0]       flag2In,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic                     busWe,
  input  logic [OC_NUM+IC_NUM-1:0] busWdata,
  output logic [OC_NUM+IC_NUM-1:0] busRdata,
  output logic                     irq,
  output logic [PRESC_W-1:0]       prescSel
);

  localparam int DATA_W = OC_NUM + IC_NUM;

  ctrlStrobe_t         strb;
  rdSel_t              rdSel;
  logic [DATA_W-1:0]   flagQ;
  logic [DATA_W-1:0]   mask1Q;
  logic [FLAG2_W-1:0]  mask2EnQ;

  tmr_irq_ctrl #(
    .ADDR_W(ADDR_W), .MASK1_ADDR(MASK1_ADDR), .FLAG_ADDR(FLAG_ADDR),
    .MASK2_ADDR(MASK2_ADDR), .WINDOW(WINDOW)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .specialMode(specialMode),
    .busAddr(busAddr), .busWe(busWe), .strb(strb), .rdSel(rdSel)
  );

  tmr_irq_dp #(
    .OC_NUM(OC_NUM), .IC_NUM(IC_NUM), .FLAG2_W(FLAG2_W), .PRESC_W(PRESC_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSel(rdSel),
    .evtPulse(evtPulse), .busWdata(busWdata), .busRdata(busRdata),
    .flagQ(flagQ), .mask1Q(mask1Q), .mask2EnQ(mask2EnQ), .prescQ(prescSel)
  );

  assign irq = (|(flagQ & mask1Q)) | (|(flag2In & mask2EnQ));

endmodule

// File: rtl/tmr_irq_chk.sv
module tmr_irq_chk #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int PRESC_W    = 2,
  parameter int FLAG_ADDR  = 'h23,
  parameter int MASK2_ADDR = 'h24,
  parameter int WINDOW     = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              specialMode,
  input logic [DATA_W-1:0] evtPulse,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              irq,
  input logic [PRESC_W-1:0] prescSel,
  input logic [DATA_W-1:0] flagQ
);

  localparam int CNT_W = $clog2(WINDOW + 1);

  logic [CNT_W-1:0] edgeCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         edgeCnt <= '0;
    else if (edgeCnt < CNT_W'(WINDOW)) edgeCnt <= edgeCnt + 1'b1;
  end

  logic flagWr, mask2Wr;
  assign flagWr  = busWe && (busAddr == ADDR_W'(FLAG_ADDR));
  assign mask2Wr = busWe && (busAddr == ADDR_W'(MASK2_ADDR));

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (evtPulse != '0) |=> ((flagQ & $past(evtPulse)) == $past(evtPulse))); // R3

  AST_NO_STRAY_SET: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flagQ & ~$past(flagQ) & ~$past(evtPulse)) == '0)); // R1

  AST_CLEAR_APPLIED: assert property (@(posedge clk) disable iff (!rstN)
    flagWr |=> ((flagQ & $past(busWdata) & ~$past(evtPulse)) == '0)); // R2

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(MASK2_ADDR)) |-> (busRdata[PRESC_W+1:PRESC_W] == 2'b00)); // R5

  AST_LATE_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (!specialMode && edgeCnt >= CNT_W'(WINDOW)) |=> $stable(prescSel)); // R8

  AST_SPECIAL_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (specialMode && mask2Wr) |=> (prescSel == $past(busWdata[PRESC_W-1:0]))); // R9

  always @(posedge clk) begin
    if (!rstN) begin
      AST_RESET_QUIET: assert (flagQ == '0 && prescSel == '0 && !irq); // R10
    end
  end

endmodule

bind tmr_irq_top tmr_irq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(OC_NUM + IC_NUM), .PRESC_W(PRESC_W),
  .FLAG_ADDR(FLAG_ADDR), .MASK2_ADDR(MASK2_ADDR), .WINDOW(WINDOW)
) chk_i (
  .clk(clk), .rstN(rstN), .specialMode(specialMode), .evtPulse(evtPulse),
  .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata),
  .irq(irq), .prescSel(prescSel), .flagQ(flagQ)
);

// File: tb/tmr_irq_top_tb_top.sv
`timescale 1ns/1ps
module tmr_irq_top_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       specialMode = 1'b0;
  logic [7:0] evtPulse = '0;
  logic [3:0] flag2In = '0;
  logic [7:0] busAddr = '0;
  logic       busWe = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       irq;
  logic [1:0] prescSel;

  always #5 clk = ~clk;

  tmr_irq_top dut_i (
    .clk(clk), .rstN(rstN), .specialMode(specialMode), .evtPulse(evtPulse),
    .flag2In(flag2In), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRdata(busRdata), .irq(irq), .prescSel(prescSel)
  );

  // behavioural reference state
  int mMask1, mFlags, mEn2, mPresc, mCyc;
  bit mUsed;
  int nChecks = 0, nFail = 0;
  bit done = 1'b0;

  function automatic int expRead();
    case (busAddr)
      8'h22:   return mMask1;
      8'h23:   return mFlags;
      8'h24:   return (mEn2 << 4) | mPresc;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic modelZero();
    mMask1 = 0; mFlags = 0; mEn2 = 0; mPresc = 0; mCyc = 0; mUsed = 0;
  endtask

  task automatic step(input string tag);
    int e;
    #1;
    e = ((mFlags & mMask1) != 0 || (flag2In & mEn2) != 0) ? 1 : 0;
    chk(tag, "irq", int'(irq), e);
    chk(tag, "rdata", int'(busRdata), expRead());
    chk(tag, "prescSel", int'(prescSel), mPresc);
    @(posedge clk);
    if (rstN) begin
      int nf;
      nf = mFlags;
      if (busWe && busAddr == 8'h23) nf = nf & ~int'(busWdata);
      nf = nf | int'(evtPulse);
      mFlags = nf;
      if (busWe && busAddr == 8'h22) mMask1 = busWdata;
      if (busWe && busAddr == 8'h24) begin
        mEn2 = busWdata[7:4];
        if (specialMode) mPresc = busWdata[1:0];
        else if (!mUsed && mCyc < 64) begin
          mPresc = busWdata[1:0];
          mUsed = 1;
        end
      end
      mCyc++;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    busWe = 0; evtPulse = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
    busAddr = a; busWdata = d; busWe = 1; step(tag);
    busWe = 0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    busAddr = a; busWe = 0; step(tag);
  endtask

  task automatic doReset();
    idle();
    rstN = 0;
    modelZero();
    repeat (3) step("R10");
    rstN = 1;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();
    rd(8'h22, "R10"); rd(8'h23, "R10"); rd(8'h24, "R10");

    // enables and first prescaler write inside the window
    wr(8'h22, 8'hA5, "R4"); rd(8'h22, "R4");
    wr(8'h24, 8'hFE, "R7"); rd(8'h24, "R5");
    wr(8'h24, 8'h01, "R7"); rd(8'h24, "R7");
    chk("R7", "prescSel held", int'(prescSel), 2);

    // flag set, irq through mask1
    busAddr = 8'h23; evtPulse = 8'h81; step("R1");
    evtPulse = 8'h00; step("R1");
    chk("R6", "irq from flags", int'(irq), 1);
    evtPulse = 8'h42; step("R1"); evtPulse = 8'h00; rd(8'h23, "R1");
    wr(8'h23, 8'h00, "R2"); rd(8'h23, "R2");
    wr(8'h23, 8'h80, "R2"); rd(8'h23, "R2");
    // same-edge set and clear
    busAddr = 8'h23; busWdata = 8'h01; busWe = 1; evtPulse = 8'h01; step("R3");
    idle(); rd(8'h23, "R3");
    chk("R3", "flag kept", int'(busRdata[0]), 1);
    wr(8'h23, 8'hFF, "R2"); rd(8'h23, "R2");
    chk("R6", "irq low after clear", int'(irq), 0);

    // second flag group against each enable
    wr(8'h24, 8'h00, "R6");
    for (int j = 0; j < 4; j++) begin
      flag2In = 4'(1 << j); rd(8'h24, "R6");
      wr(8'h24, 8'(1 << (j + 4)), "R6");
      rd(8'h24, "R6");
      chk("R6", "irq flag2 pair", int'(irq), 1);
      flag2In = 4'(~(1 << j)); rd(8'h24, "R6");
      chk("R6", "irq flag2 unpaired", int'(irq), 0);
      wr(8'h24, 8'h00, "R6");
    end
    flag2In = 4'hF; rd(8'h24, "R6"); flag2In = 4'h0;

    // unmapped addresses
    wr(8'h25, 8'hFF, "R11"); rd(8'h25, "R11"); rd(8'h21, "R11");
    rd(8'h22, "R11"); rd(8'h24, "R11");

    // late write with no earlier write
    doReset();
    repeat (70) rd(8'h00, "R8");
    wr(8'h24, 8'h13, "R8"); rd(8'h24, "R8");
    chk("R8", "late write refused", int'(prescSel), 0);

    // special mode: repeated writes
    specialMode = 1;
    wr(8'h24, 8'h02, "R9"); rd(8'h24, "R9");
    wr(8'h24, 8'h03, "R9"); rd(8'h24, "R9");
    chk("R9", "special rewrite", int'(prescSel), 3);
    specialMode = 0;
    wr(8'h24, 8'h01, "R8"); rd(8'h24, "R8");

    // last edge of the window (edge 63) is accepted
    doReset();
    repeat (63) rd(8'h00, "R7");
    wr(8'h24, 8'h02, "R7"); rd(8'h24, "R7");
    chk("R7", "last window edge", int'(prescSel), 2);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule